// File: doc/BRIEF.md
# Paged Work-RAM Window with Capture Latch

This block steers CPU accesses that fall in the 8 KiB window at 0x6000–0x7FFF. A mode byte, written through a register decoded at 0xA001, chooses where the window goes. Eight mode codes map the window onto one of four 8 KiB pages of an external 32 KiB RAM. Every other code sends the window through to the CPU bank that is normally mapped there. One page code also copies each write into that normal bank.

The block also holds a three-byte capture latch. In three arming modes, writes to fixed addresses in the 0x5000–0x5FFF range are stored and a pending flag is raised. While the flag is up, reads of the matching addresses in the 0x6000 window return the stored bytes instead of memory. Reading the last of the three bytes drops the flag.

Writes and latch captures take effect on the clock edge where the write strobe is high. Read data is formed combinationally from the RAM port, the bank port or the latch.

Top module: `wram_window`

## Requirements
- R1: After reset the mode byte is 0x00, all three latch bytes are 0x00 and the pending flag is clear, so window reads return fall-through bank data.
- R2: Mode codes 0xE4/0xEC select RAM page 0, 0xE5/0xED page 1, 0xE6/0xEE page 2 and 0xE7/0xEF page 3. The RAM address is {page[1:0], cpu_addr[12:0]}, and window reads and writes go to that RAM.
- R3: With any other mode code, window reads return bank_rdata and window writes assert bank_we with bank_addr = cpu_addr[12:0]. ram_we stays low.
- R4: In mode 0xE4 or 0xEC, a window write asserts both ram_we (page 0) and bank_we.
- R5: The mode byte loads from a write whose address satisfies (cpu_addr & 0xE001) == 0xA001, for example 0xA001 or 0xA003. A write to any other address, for example 0xA000, leaves it unchanged.
- R6: In modes 0xA1, 0xA5 and 0xA9, a write to 0x5000, 0x5010 or 0x5013 stores the data in latch byte 0, 1 or 2 respectively and sets the pending flag.
- R7: In those modes, a write to any other 0x5000–0x5FFF address sets the pending flag and changes no latch byte. In all other modes, writes to 0x5000–0x5FFF leave both the flag and the latch bytes unchanged.
- R8: While the flag is set, reads of 0x6000, 0x6010 and 0x6013 return latch bytes 0, 1 and 2, whatever the mode.
- R9: A read of 0x6013 while the flag is set clears the flag at that clock edge. Later reads of those addresses follow the mode paging again.
- R10: While the flag is set, reads of any other window address follow the mode paging of R2 and R3.
- R11: Accesses outside 0x6000–0x7FFF raise no RAM or bank strobe, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data for window accesses (combinational) |
| ram_addr | output | 15 | 32 KiB RAM address {page, offset} |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data |
| bank_addr | output | 13 | Offset into the normally mapped CPU bank |
| bank_sel | output | 1 | Window access is routed to the normal bank |
| bank_wdata | output | 8 | Bank write data |
| bank_we | output | 1 | Bank write enable |
| bank_rdata | input | 8 | Bank read data |

## Verification
The memory models return data that depends on every address bit, including the page bits. A read therefore tells apart the four pages, the fall-through bank and the latch. All eight page codes are tried, along with a code just outside the page group, and the mode register is hit at a mirrored address and at a non-decoding neighbour. The latch is armed by a full three-byte capture and also by a stray write that only raises the flag. Reads of latch addresses and of neighbouring addresses show that the override is limited to the three latch addresses and ends after the read of 0x6013. Write-strobe probes separate the RAM-only, bank-only and mirrored write cases and the accesses outside the window. A mid-run reset shows that both the flag and the bytes return to zero.

// File: rtl/wram_pkg.sv
package wram_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int OFS_W   = 13;
  localparam int PG_W    = 2;
  localparam int RAM_W   = PG_W + OFS_W;
  localparam int LATCH_N = 3;

  // Offsets (low 12 bits) shared by the capture range and the readback range.
  localparam logic [11:0] LATCH_OFS [LATCH_N] = '{12'h000, 12'h010, 12'h013};
  localparam logic [3:0]  CAPT_NIB  = 4'h5;
  localparam logic [3:0]  READ_NIB  = 4'h6;
  localparam logic [2:0]  WIN_TOP   = 3'b011;
  localparam logic [15:0] MODE_MASK = 16'hE001;
  localparam logic [15:0] MODE_HIT  = 16'hA001;

  // Page codes: high nibble E with bit 2 set; bits 1:0 give the page.
  function automatic logic mode_is_paged(input logic [7:0] m);
    return (m[7:4] == 4'hE) && m[2];
  endfunction

  // Page 0 codes also copy writes into the normal bank.
  function automatic logic mode_mirrors(input logic [7:0] m);
    return mode_is_paged(m) && (m[1:0] == 2'b00);
  endfunction

  function automatic logic mode_arms_latch(input logic [7:0] m);
    return (m == 8'hA1) || (m == 8'hA5) || (m == 8'hA9);
  endfunction
endpackage

// File: rtl/wram_mode_reg.sv
module wram_mode_reg
  import wram_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_wr,
  output logic [DW-1:0]     mode_q
);
  logic load;
  assign load = cpu_wr && ((cpu_addr & MODE_MASK) == MODE_HIT);

  always_ff @(posedge clk) begin
    if (rst)       mode_q <= '0;
    else if (load) mode_q <= cpu_wdata;
  end

  assert_reset_mode_R1: assert property (@(posedge clk) rst |=> (mode_q == '0));
  assert_mode_load_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && ((cpu_addr & MODE_MASK) == MODE_HIT)) |=> (mode_q == $past(cpu_wdata)));
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && ((cpu_addr & MODE_MASK) == MODE_HIT)) |=> $stable(mode_q));
endmodule

// File: rtl/wram_latch.sv
module wram_latch
  import wram_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NB = LATCH_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              armed,
  output logic              hit,
  output logic [DW-1:0]     hit_data
);
  logic          cap_en;
  logic          pending;
  logic [NB-1:0] cap_match;
  logic [NB-1:0] rd_match;
  logic [DW-1:0] byte_q [NB];
  logic          last_read;

  assign cap_en = cpu_wr && armed && (cpu_addr[15:12] == CAPT_NIB);

  for (genvar i = 0; i < NB; i++) begin : g_slot
    assign cap_match[i] = cap_en && (cpu_addr[11:0] == LATCH_OFS[i]);
    assign rd_match[i]  = pending && cpu_rd &&
                          (cpu_addr[15:12] == READ_NIB) &&
                          (cpu_addr[11:0] == LATCH_OFS[i]);
    always_ff @(posedge clk) begin
      if (rst)               byte_q[i] <= '0;
      else if (cap_match[i]) byte_q[i] <= cpu_wdata;
    end
  end

  assign last_read = rd_match[NB-1];
  assign hit       = |rd_match;

  always_comb begin
    hit_data = '0;
    for (int k = 0; k < NB; k++)
      if (rd_match[k]) hit_data = hit_data | byte_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)            pending <= 1'b0;
    else if (cap_en)    pending <= 1'b1;
    else if (last_read) pending <= 1'b0;
  end

  assert_reset_flag_R1: assert property (@(posedge clk) rst |=> !pending);
  assert_capture_sets_R6: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> pending);
  assert_last_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (last_read && !cap_en) |=> !pending);
  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !last_read) |=> $stable(pending));
  assert_single_slot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_match));
endmodule

// File: rtl/wram_route.sv
module wram_route
  import wram_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     mode,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              hit,
  input  logic [DW-1:0]     hit_data,
  input  logic [DW-1:0]     ram_rdata,
  input  logic [DW-1:0]     bank_rdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic [PG_W+OW-1:0] ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              ram_we,
  output logic [OW-1:0]     bank_addr,
  output logic              bank_sel,
  output logic [DW-1:0]     bank_wdata,
  output logic              bank_we
);
  logic in_win, paged, mirror;

  assign in_win = (cpu_addr[15:13] == WIN_TOP);
  assign paged  = mode_is_paged(mode);
  assign mirror = mode_mirrors(mode);

  assign ram_addr   = {mode[PG_W-1:0], cpu_addr[OW-1:0]};
  assign bank_addr  = cpu_addr[OW-1:0];
  assign ram_wdata  = cpu_wdata;
  assign bank_wdata = cpu_wdata;

  assign ram_we   = in_win && cpu_wr && paged;
  assign bank_we  = in_win && cpu_wr && (!paged || mirror);
  assign bank_sel = bank_we || (in_win && cpu_rd && !paged && !hit);

  always_comb begin
    if (hit)                 cpu_rdata = hit_data;
    else if (in_win && paged) cpu_rdata = ram_rdata;
    else if (in_win)          cpu_rdata = bank_rdata;
    else                      cpu_rdata = '0;
  end

  assert_outside_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:13] != WIN_TOP) |-> (!ram_we && !bank_we && !bank_sel));
  assert_dual_write_R4: assert property (@(posedge clk) disable iff (rst)
    (ram_we && bank_we) |-> ((mode[7:4] == 4'hE) && (mode[1:0] == 2'b00)));
  assert_ram_needs_page_R2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ((mode[7:4] == 4'hE) && mode[2] && cpu_wr));
  assert_fallthrough_R3: assert property (@(posedge clk) disable iff (rst)
    (in_win && cpu_wr && (mode[7:4] != 4'hE)) |-> (bank_we && !ram_we));
endmodule

// File: rtl/wram_window.sv
module wram_window
  import wram_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OFS_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DW-1:0]        cpu_wdata,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  output logic [DW-1:0]        cpu_rdata,
  output logic [PG_W+OW-1:0]   ram_addr,
  output logic [DW-1:0]        ram_wdata,
  output logic                 ram_we,
  input  logic [DW-1:0]        ram_rdata,
  output logic [OW-1:0]        bank_addr,
  output logic                 bank_sel,
  output logic [DW-1:0]        bank_wdata,
  output logic                 bank_we,
  input  logic [DW-1:0]        bank_rdata
);
  logic [DW-1:0] mode_q;
  logic          hit;
  logic [DW-1:0] hit_data;

  wram_mode_reg #(.DW(DW)) u_mode (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .mode_q(mode_q)
  );

  wram_latch #(.DW(DW), .NB(LATCH_N)) u_latch (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .armed(mode_arms_latch(mode_q)),
    .hit(hit), .hit_data(hit_data)
  );

  wram_route #(.DW(DW), .OW(OW)) u_route (
    .clk(clk), .rst(rst), .mode(mode_q), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .hit(hit), .hit_data(hit_data), .ram_rdata(ram_rdata),
    .bank_rdata(bank_rdata), .cpu_rdata(cpu_rdata), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .bank_addr(bank_addr),
    .bank_sel(bank_sel), .bank_wdata(bank_wdata), .bank_we(bank_we)
  );
endmodule

// File: tb/wram_window_bench.sv
module wram_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] KW = 2'd0, KB = 2'd1, KR = 2'd2, KL = 2'd3;
  localparam int NVEC = 49;
  // entry = {kind[1:0], page[1:0], addr[15:0], data[7:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {KB,2'd0,16'h6000,8'h00},  // R1 reset: fall-through
    {KW,2'd0,16'hA001,8'hE4},
    {KW,2'd0,16'h6123,8'h11},
    {KR,2'd0,16'h6123,8'h00},  // R2 page 0
    {KW,2'd0,16'hA001,8'hED},
    {KR,2'd1,16'h7FFF,8'h00},  // R2 page 1
    {KW,2'd0,16'hA001,8'hE6},
    {KR,2'd2,16'h6000,8'h00},  // R2 page 2
    {KW,2'd0,16'hA001,8'hEF},
    {KR,2'd3,16'h6ABC,8'h00},  // R2 page 3
    {KW,2'd0,16'hA001,8'hE8},
    {KB,2'd0,16'h6ABC,8'h00},  // R3 other code
    {KW,2'd0,16'hA000,8'hE5},
    {KB,2'd0,16'h6ABC,8'h00},  // R5 A000 ignored
    {KW,2'd0,16'hA003,8'hE5},
    {KR,2'd1,16'h6002,8'h00},  // R5 A003 decodes
    {KW,2'd0,16'hA001,8'hA5},
    {KW,2'd0,16'h5000,8'h11},  // R6
    {KW,2'd0,16'h5010,8'h22},
    {KW,2'd0,16'h5013,8'h33},
    {KL,2'd0,16'h6000,8'h11},  // R8
    {KL,2'd0,16'h6010,8'h22},
    {KB,2'd0,16'h6011,8'h00},  // R10 neighbour
    {KL,2'd0,16'h6013,8'h33},
    {KB,2'd0,16'h6013,8'h00},  // R9 cleared
    {KB,2'd0,16'h6000,8'h00},
    {KW,2'd0,16'hA001,8'hA9},
    {KW,2'd0,16'h5ABC,8'h77},  // R7 stray write arms
    {KW,2'd0,16'hA001,8'hE6},
    {KL,2'd0,16'h6000,8'h11},
    {KR,2'd2,16'h6001,8'h00},  // R10 paged neighbour
    {KL,2'd0,16'h6010,8'h22},
    {KL,2'd0,16'h6013,8'h33},
    {KR,2'd2,16'h6013,8'h00},  // R9
    {KW,2'd0,16'hA001,8'hE4},
    {KW,2'd0,16'h5000,8'h99},  // R7 not armed
    {KR,2'd0,16'h6000,8'h00},
    {KW,2'd0,16'hA001,8'hA1},
    {KW,2'd0,16'h5FFF,8'h01},
    {KL,2'd0,16'h6000,8'h11},  // R7 byte 0 untouched
    {KL,2'd0,16'h6013,8'h33},
    {KW,2'd0,16'hA001,8'hEC},
    {KR,2'd0,16'h7000,8'h00},  // R2 EC
    {KW,2'd0,16'hA001,8'hE5},
    {KR,2'd1,16'h6FFF,8'h00},  // R2 E5
    {KW,2'd0,16'hA001,8'hEE},
    {KR,2'd2,16'h7123,8'h00},  // R2 EE
    {KW,2'd0,16'hA001,8'hE7},
    {KR,2'd3,16'h6001,8'h00}   // R2 E7
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_rdata;
  logic [14:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        ram_we;
  logic [12:0] bank_addr;
  logic        bank_sel, bank_we;
  logic [7:0]  bank_wdata, bank_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic        s_ram_we, s_bank_we, s_bank_sel;
  logic [14:0] s_ram_addr;
  logic [7:0]  s_rdata;

  function automatic logic [7:0] ram_fn(input logic [14:0] a);
    return a[7:0] ^ {1'b1, a[14:13], a[12:8]};
  endfunction
  function automatic logic [7:0] bank_fn(input logic [12:0] a);
    return ~a[7:0] ^ {3'b000, a[12:8]};
  endfunction

  assign ram_rdata  = ram_fn(ram_addr);
  assign bank_rdata = bank_fn(bank_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  wram_window u_wram_window (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .bank_addr(bank_addr), .bank_sel(bank_sel),
    .bank_wdata(bank_wdata), .bank_we(bank_we), .bank_rdata(bank_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1;
    s_ram_we = ram_we; s_bank_we = bank_we; s_bank_sel = bank_sel;
    s_ram_addr = ram_addr;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1;
    s_rdata = cpu_rdata; s_bank_sel = bank_sel; s_ram_we = ram_we;
    @(posedge clk);
    #1 cpu_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      automatic logic [27:0] v = VEC[i];
      automatic logic [1:0]  kind = v[27:26];
      automatic logic [1:0]  pg = v[25:24];
      automatic logic [15:0] a = v[23:8];
      automatic logic [7:0]  d = v[7:0];
      if (kind == KW) bus_write(a, d);
      else begin
        bus_read(a);
        case (kind)
          KB: check($sformatf("R3/R1 fall-through vec %0d", i), s_rdata, bank_fn(a[12:0]));
          KR: check($sformatf("R2 paged read vec %0d", i), s_rdata, ram_fn({pg, a[12:0]}));
          default: check($sformatf("R8 latch readback vec %0d", i), s_rdata, d);
        endcase
      end
    end

    // R4: page 0 code writes RAM and bank together
    bus_write(16'hA001, 8'hE4);
    bus_write(16'h6055, 8'h5A);
    check("R4 ram_we", s_ram_we, 1'b1);
    check("R4 bank_we", s_bank_we, 1'b1);
    check("R4 ram_addr", s_ram_addr, 15'h0055);
    // R3: fall-through write strobes bank only
    bus_write(16'hA001, 8'h42);
    bus_write(16'h7055, 8'h5A);
    check("R3 ram_we", s_ram_we, 1'b0);
    check("R3 bank_we", s_bank_we, 1'b1);
    // R2: page 1 write strobes RAM only
    bus_write(16'hA001, 8'hED);
    bus_write(16'h7055, 8'h5A);
    check("R2 ram_we", s_ram_we, 1'b1);
    check("R2 bank_we", s_bank_we, 1'b0);
    check("R2 ram_addr", s_ram_addr, 15'h3055);
    // R11: outside the window
    bus_write(16'h8000, 8'h12);
    check("R11 ram_we", s_ram_we, 1'b0);
    check("R11 bank_we", s_bank_we, 1'b0);
    bus_read(16'h4000);
    check("R11 bank_sel", s_bank_sel, 1'b0);
    check("R11 rdata", s_rdata, 8'h00);
    bus_read(16'h6000);
    check("R5 8000 write left mode", s_rdata, ram_fn(15'h2000));

    // R1: reset mid-run clears mode, flag and bytes
    bus_write(16'hA001, 8'hA1);
    bus_write(16'h5000, 8'hAA);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    bus_read(16'h6000);
    check("R1 flag cleared", s_rdata, bank_fn(13'h0000));
    bus_write(16'hA001, 8'hA1);
    bus_write(16'h5ABC, 8'h55);
    bus_read(16'h6000);
    check("R1 byte reset", s_rdata, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule